// File: doc/BRIEF.md
# Bidirectional FIFO Port with Mailbox Bypass

This block is one side (port B) of a pair of synchronous queues that carry data in opposite directions, with a pair of single-word mailbox registers beside them. A single 18-bit bus, run by its own clock, serves both directions. A read/write select, an active-low enable, an active-low output enable and a 3-bit address pick the operation on each clock edge. Writes push the bus word into the queue toward the far side, or load the outbound mailbox when the mailbox address is given. Reads pop the queue from the far side into the port's output register, or copy the inbound mailbox into it.

The bus is modelled as a data output plus a registered drive enable, which is the control for the three-state buffer. A write select on any edge turns the driver off for the next cycle, whatever the output enable level. A write placed right after a cycle in which the bus was driven is refused and reported. The far side is reduced to plain push, pop and mailbox-load strobes, so that the block can be used and checked on its own. Both queues run on the one port clock.

Top module: `bxp_port`

## Requirements
- R1: A synchronous active-high reset empties both queues and clears the output register, both mailboxes, the read word on the far side, the error output and the drive enable.
- R2: With `rw_sel`=0, `en_n`=0 and `addr`≠3'b001, the bus word is pushed into the outbound queue on the clock edge, provided the bus was not driven in the previous cycle. The far side pops the words in the order they were written.
- R3: After any clock edge that sees `rw_sel`=0, `bus_drive` is 0 for the following cycle, even when `oe_n` is 0.
- R4: With `rw_sel`=1, `en_n`=0 and `addr` equal to 3'b000 or 3'b1xx, the next inbound queue word appears on `bus_out` after that edge. `bus_drive` follows `oe_n` sampled at the same edge (1 when `oe_n`=0).
- R5: With `rw_sel`=1 and `en_n`=1, `bus_out` keeps its value and the inbound queue is not popped. `bus_drive` still follows the sampled `oe_n`.
- R6: With `rw_sel`=0 and `en_n`=1, the bus word is ignored: neither queue nor mailbox changes.
- R7: A read with `addr`=3'b001 copies the inbound mailbox (loaded by `a_byp_we`) to `bus_out` and does not pop the inbound queue.
- R8: A write with `addr`=3'b001 loads the bus word into the outbound mailbox, seen on `a_byp_rdata`, and does not push the outbound queue.
- R9: A write cycle (`rw_sel`=0, `en_n`=0) at an edge where `bus_drive` is 1 is not performed, and `wr_err` is 1 for the next cycle.
- R10: A pop from an empty queue leaves its read word unchanged. A push into a full queue is dropped.
- R11: A read with `addr` equal to 3'b010 or 3'b011 is no operation: `bus_out` is unchanged and nothing is popped.
- R12: Each queue holds `DEPTH` words (256 or 512). Its full flag rises after `DEPTH` accepted pushes and its empty flag after all words have been popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous reset, active high |
| rw_sel | input | 1 | 1 = read from port, 0 = write into port |
| en_n | input | 1 | Cycle enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 3 | Operation address: 001 mailbox, others queue |
| bus_in | input | 18 | Bus word presented for writes |
| bus_out | output | 18 | Output register value toward the bus |
| bus_drive | output | 1 | Three-state buffer enable for the bus |
| wr_err | output | 1 | Pulse: write refused after a driven cycle |
| a_push | input | 1 | Far side pushes into the inbound queue |
| a_wdata | input | 18 | Word for the inbound queue |
| a_pop | input | 1 | Far side pops the outbound queue |
| a_rdata | output | 18 | Last word popped from the outbound queue |
| a_byp_we | input | 1 | Far side loads the inbound mailbox |
| a_byp_wdata | input | 18 | Word for the inbound mailbox |
| a_byp_rdata | output | 18 | Outbound mailbox contents |
| a2b_empty | output | 1 | Inbound queue empty |
| a2b_full | output | 1 | Inbound queue full |
| b2a_empty | output | 1 | Outbound queue empty |
| b2a_full | output | 1 | Outbound queue full |

## Verification
The assertions watch the bus control on every cycle: write select turning the driver off, output enable turning it on, the output holding while the port is disabled, and a refused write leaving the outbound queue's fill level untouched. They also check that mailbox reads never move the inbound queue and that a full or empty queue refuses the access. Ordering of queue words, the exact word returned by each address pattern, dropped pushes at the full boundary and the reset values of every register can only be shown by the bench's scenarios. These scenarios compare the words that come out against the words that went in.

// File: rtl/bxp_pkg.sv
package bxp_pkg;
  // Address codes that change the port's behaviour
  localparam logic [2:0] ADDR_MAILBOX = 3'b001;
  localparam logic [2:0] ADDR_QUEUE0  = 3'b000;

  // Decoded operation of one port cycle
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_PUSH,
    OP_MB_WRITE,
    OP_POP,
    OP_MB_READ,
    OP_REFUSED
  } port_op_e;
endpackage

// File: rtl/bxp_queue.sv
module bxp_queue #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int unsigned FULL_LEVEL = DEPTH;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      cnt;
  logic             push_ok, pop_ok;

  initial begin
    assert (DEPTH == 256 || DEPTH == 512)
      else $error("bxp_queue: DEPTH must be 256 or 512");
  end

  assign empty   = (cnt == '0);
  assign full    = (cnt == FULL_LEVEL[AW:0]);
  assign level   = cnt;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  // Storage without reset so that it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (pop_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R10: a push into a full queue with no pop leaves it full at the same level
  p_full_push_dropped_r10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(level)));

  // R10: a pop from an empty queue leaves the read word alone
  p_empty_pop_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (empty && pop) |=> $stable(rdata));

  // R12: the level never passes the depth
  p_level_bound_r12: assert property (@(posedge clk) disable iff (rst)
    level <= FULL_LEVEL[AW:0]);
endmodule

// File: rtl/bxp_decode.sv
module bxp_decode
  import bxp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rw_sel,
  input  logic       en_n,
  input  logic       oe_n,
  input  logic [2:0] addr,
  output logic       q_push,
  output logic       mb_write,
  output logic       q_pop,
  output logic       mb_read,
  output logic       bus_drive,
  output logic       wr_err
);
  port_op_e op;
  logic     drive_q;
  logic     err_q;
  logic     is_mb;
  logic     is_qread;

  assign is_mb    = (addr == ADDR_MAILBOX);
  assign is_qread = (addr == ADDR_QUEUE0) || addr[2];

  always_comb begin
    op = OP_IDLE;
    if (!en_n) begin
      if (!rw_sel) begin
        if (drive_q)    op = OP_REFUSED;
        else if (is_mb) op = OP_MB_WRITE;
        else            op = OP_PUSH;
      end else begin
        if (is_mb)         op = OP_MB_READ;
        else if (is_qread) op = OP_POP;
        else               op = OP_IDLE;
      end
    end
  end

  assign q_push   = (op == OP_PUSH);
  assign mb_write = (op == OP_MB_WRITE);
  assign q_pop    = (op == OP_POP);
  assign mb_read  = (op == OP_MB_READ);

  // Bus driver enable: write select overrides output enable
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      drive_q <= rw_sel && !oe_n;
      err_q   <= (op == OP_REFUSED);
    end
  end

  assign bus_drive = drive_q;
  assign wr_err    = err_q;

  // R3: write select turns the driver off for the next cycle
  p_write_hiz_r3: assert property (@(posedge clk) disable iff (rst)
    !rw_sel |=> !bus_drive);

  // R4: read select with output enable low drives the bus next cycle
  p_read_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (rw_sel && !oe_n) |=> bus_drive);

  // R9: a refused write never produces a push or mailbox write strobe
  p_refused_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_drive && !rw_sel) |-> !(q_push || mb_write));

  // R2: at most one strobe per cycle
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({q_push, mb_write, q_pop, mb_read}));
endmodule

// File: rtl/bxp_mailbox.sv
module bxp_mailbox #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_we,
  input  logic [WIDTH-1:0] in_wdata,
  input  logic             out_we,
  input  logic [WIDTH-1:0] out_wdata,
  output logic [WIDTH-1:0] in_word,
  output logic [WIDTH-1:0] out_word
);
  // Inbound mailbox loaded from the far side, outbound loaded from the port
  always_ff @(posedge clk) begin
    if (rst) begin
      in_word  <= '0;
      out_word <= '0;
    end else begin
      if (in_we)  in_word  <= in_wdata;
      if (out_we) out_word <= out_wdata;
    end
  end

  // R8: the outbound mailbox changes only on a port mailbox write
  p_out_mb_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !out_we |=> $stable(out_word));
endmodule

// File: rtl/bxp_port.sv
module bxp_port #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rw_sel,
  input  logic             en_n,
  input  logic             oe_n,
  input  logic [2:0]       addr,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_drive,
  output logic             wr_err,
  input  logic             a_push,
  input  logic [WIDTH-1:0] a_wdata,
  input  logic             a_pop,
  output logic [WIDTH-1:0] a_rdata,
  input  logic             a_byp_we,
  input  logic [WIDTH-1:0] a_byp_wdata,
  output logic [WIDTH-1:0] a_byp_rdata,
  output logic             a2b_empty,
  output logic             a2b_full,
  output logic             b2a_empty,
  output logic             b2a_full
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic             q_push, mb_write, q_pop, mb_read;
  logic [WIDTH-1:0] a2b_rdata;
  logic [WIDTH-1:0] mb_in_word;
  logic [LW-1:0]    a2b_level, b2a_level;
  logic             out_sel_mb;
  logic [WIDTH-1:0] out_mb_q;

  bxp_decode u_decode (
    .clk       (clk),
    .rst       (rst),
    .rw_sel    (rw_sel),
    .en_n      (en_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .q_push    (q_push),
    .mb_write  (mb_write),
    .q_pop     (q_pop),
    .mb_read   (mb_read),
    .bus_drive (bus_drive),
    .wr_err    (wr_err)
  );

  // Far side toward port B
  bxp_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_a2b (
    .clk   (clk),
    .rst   (rst),
    .push  (a_push),
    .wdata (a_wdata),
    .pop   (q_pop),
    .rdata (a2b_rdata),
    .empty (a2b_empty),
    .full  (a2b_full),
    .level (a2b_level)
  );

  // Port B toward far side
  bxp_queue #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_b2a (
    .clk   (clk),
    .rst   (rst),
    .push  (q_push),
    .wdata (bus_in),
    .pop   (a_pop),
    .rdata (a_rdata),
    .empty (b2a_empty),
    .full  (b2a_full),
    .level (b2a_level)
  );

  bxp_mailbox #(.WIDTH(WIDTH)) u_mailbox (
    .clk       (clk),
    .rst       (rst),
    .in_we     (a_byp_we),
    .in_wdata  (a_byp_wdata),
    .out_we    (mb_write),
    .out_wdata (bus_in),
    .in_word   (mb_in_word),
    .out_word  (a_byp_rdata)
  );

  // Output register: either the queue read word or a captured mailbox word
  always_ff @(posedge clk) begin
    if (rst) begin
      out_sel_mb <= 1'b0;
      out_mb_q   <= '0;
    end else if (mb_read) begin
      out_sel_mb <= 1'b1;
      out_mb_q   <= mb_in_word;
    end else if (q_pop && !a2b_empty) begin
      out_sel_mb <= 1'b0;
    end
  end

  assign bus_out = out_sel_mb ? out_mb_q : a2b_rdata;

  // R5: disabled read cycle keeps the output
  p_hold_output_r5: assert property (@(posedge clk) disable iff (rst)
    (rw_sel && en_n) |=> $stable(bus_out));

  // R9: a refused write leaves the outbound level untouched and raises the error
  p_refused_write_r9: assert property (@(posedge clk) disable iff (rst)
    (!rw_sel && !en_n && bus_drive && !a_pop) |=> (wr_err && $stable(b2a_level)));

  // R7: a mailbox read does not pop the inbound queue
  p_mb_read_no_pop_r7: assert property (@(posedge clk) disable iff (rst)
    (rw_sel && !en_n && addr == 3'b001 && !a_push) |=> $stable(a2b_level));

  // R7: a mailbox read returns the mailbox word present at the edge
  p_mb_read_value_r7: assert property (@(posedge clk) disable iff (rst)
    (rw_sel && !en_n && addr == 3'b001) |=> (bus_out == $past(mb_in_word)));

  // R6: an ignored write changes no queue level on the port side
  p_ignored_write_r6: assert property (@(posedge clk) disable iff (rst)
    (!rw_sel && en_n && !a_pop) |=> $stable(b2a_level));
endmodule

// File: tb/test_bxp_port.sv
module test_bxp_port;
  localparam int W = 18;
  localparam int D = 256;

  logic         clk = 1'b0;
  logic         rst;
  logic         rw_sel, en_n, oe_n;
  logic [2:0]   addr;
  logic [W-1:0] bus_in;
  logic [W-1:0] bus_out;
  logic         bus_drive, wr_err;
  logic         a_push, a_pop, a_byp_we;
  logic [W-1:0] a_wdata, a_rdata, a_byp_wdata, a_byp_rdata;
  logic         a2b_empty, a2b_full, b2a_empty, b2a_full;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bxp_port #(.WIDTH(W), .DEPTH(D)) i_bxp_port (
    .clk(clk), .rst(rst), .rw_sel(rw_sel), .en_n(en_n), .oe_n(oe_n),
    .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
    .wr_err(wr_err), .a_push(a_push), .a_wdata(a_wdata), .a_pop(a_pop),
    .a_rdata(a_rdata), .a_byp_we(a_byp_we), .a_byp_wdata(a_byp_wdata),
    .a_byp_rdata(a_byp_rdata), .a2b_empty(a2b_empty), .a2b_full(a2b_full),
    .b2a_empty(b2a_empty), .b2a_full(b2a_full)
  );

  // Vector: rw, en_n, oe_n, addr[3], bus_in[18], exp_drive, exp_out[18], exp_err
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 3'b000, 18'h00000, 1'b1, 18'h00011, 1'b0},
    {1'b1, 1'b1, 1'b0, 3'b000, 18'h00000, 1'b1, 18'h00011, 1'b0},
    {1'b1, 1'b0, 1'b1, 3'b001, 18'h00000, 1'b0, 18'h2AAAA, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'b010, 18'h00000, 1'b1, 18'h2AAAA, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'b100, 18'h00000, 1'b1, 18'h00022, 1'b0},
    {1'b0, 1'b0, 1'b0, 3'b000, 18'h15555, 1'b0, 18'h00022, 1'b1},
    {1'b0, 1'b0, 1'b0, 3'b000, 18'h0ABCD, 1'b0, 18'h00022, 1'b0},
    {1'b0, 1'b1, 1'b0, 3'b000, 18'h3FFFF, 1'b0, 18'h00022, 1'b0},
    {1'b0, 1'b0, 1'b1, 3'b001, 18'h12345, 1'b0, 18'h00022, 1'b0},
    {1'b1, 1'b1, 1'b1, 3'b000, 18'h00000, 1'b0, 18'h00022, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'b111, 18'h00000, 1'b1, 18'h00033, 1'b0},
    {1'b1, 1'b0, 1'b0, 3'b000, 18'h00000, 1'b1, 18'h00033, 1'b0}
  };

  string tags [NV];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic port_idle();
    rw_sel = 1'b1; en_n = 1'b1; oe_n = 1'b1; addr = 3'b000; bus_in = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tags = '{"R4", "R5", "R7", "R11", "R4", "R9", "R2", "R6", "R8", "R5", "R4", "R10"};
    rst = 1'b1;
    port_idle();
    a_push = 1'b0; a_pop = 1'b0; a_byp_we = 1'b0;
    a_wdata = '0; a_byp_wdata = '0;
    step();
    step();
    rst = 1'b0;
    step();

    // R1: reset state
    chk("R1 drive", 32'(bus_drive), 0);
    chk("R1 out", 32'(bus_out), 0);
    chk("R1 err", 32'(wr_err), 0);
    chk("R1 empties", 32'({a2b_empty, b2a_empty, a2b_full, b2a_full}), 32'b1100);
    chk("R1 mailbox", 32'(a_byp_rdata), 0);

    // Preload the inbound queue and the inbound mailbox from the far side
    for (int k = 1; k <= 3; k++) begin
      a_push = 1'b1; a_wdata = W'(k * 17);
      step();
    end
    a_push = 1'b0;
    a_byp_we = 1'b1; a_byp_wdata = 18'h2AAAA;
    step();
    a_byp_we = 1'b0;

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      rw_sel = VEC[i][43];
      en_n   = VEC[i][42];
      oe_n   = VEC[i][41];
      addr   = VEC[i][40:38];
      bus_in = VEC[i][37:20];
      step();
      chk({tags[i], " drive"}, 32'(bus_drive), 32'(VEC[i][19]));
      chk({tags[i], " out"},   32'(bus_out),   32'(VEC[i][18:1]));
      chk({tags[i], " err"},   32'(wr_err),    32'(VEC[i][0]));
    end
    port_idle();

    // R2/R6/R9: only the accepted write reached the outbound queue
    chk("R2 b2a not empty", 32'(b2a_empty), 0);
    a_pop = 1'b1;
    step();
    a_pop = 1'b0;
    chk("R2 a_rdata", 32'(a_rdata), 32'h0ABCD);
    chk("R6 R9 b2a empty after one pop", 32'(b2a_empty), 1);
    chk("R8 mailbox word", 32'(a_byp_rdata), 32'h12345);
    chk("R4 a2b empty", 32'(a2b_empty), 1);
    chk("R9 err cleared", 32'(wr_err), 0);

    // R12/R10: fill the inbound queue, overfill, then drain through the port
    for (int k = 0; k < D; k++) begin
      a_push = 1'b1; a_wdata = W'(k + 100);
      step();
    end
    chk("R12 a2b full", 32'(a2b_full), 1);
    a_wdata = 18'h3FFFF;
    step();
    a_push = 1'b0;
    chk("R10 a2b still full", 32'(a2b_full), 1);
    rw_sel = 1'b1; en_n = 1'b0; oe_n = 1'b0; addr = 3'b000;
    for (int k = 0; k < D; k++) begin
      step();
      chk("R4 R12 drain order", 32'(bus_out), 32'(k + 100));
    end
    chk("R10 dropped push left empty", 32'(a2b_empty), 1);
    step();
    chk("R10 empty pop holds", 32'(bus_out), 32'(D - 1 + 100));

    // R12: fill the outbound queue from the port
    rw_sel = 1'b0; en_n = 1'b1;
    step();
    for (int k = 0; k < D; k++) begin
      en_n = 1'b0; bus_in = W'(k + 7);
      step();
    end
    chk("R12 b2a full", 32'(b2a_full), 1);
    bus_in = 18'h3FFFF;
    step();
    port_idle();
    a_pop = 1'b1;
    step();
    a_pop = 1'b0;
    chk("R12 b2a first word", 32'(a_rdata), 7);
    chk("R12 b2a not full", 32'(b2a_full), 0);

    // R1: reset from a busy state
    rw_sel = 1'b1; en_n = 1'b0; oe_n = 1'b0; addr = 3'b001;
    rst = 1'b1;
    step();
    rst = 1'b0;
    port_idle();
    chk("R1 drive after reset", 32'(bus_drive), 0);
    chk("R1 out after reset", 32'(bus_out), 0);
    chk("R1 flags after reset", 32'({a2b_empty, b2a_empty, b2a_full}), 32'b110);
    chk("R1 mailbox after reset", 32'(a_byp_rdata), 0);
    chk("R1 a_rdata after reset", 32'(a_rdata), 0);

    finish_run();
  end
endmodule